// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block gives a host a two-register path into the configuration space of a set of attached functions. The host first loads a 32-bit address register that selects a bus, a device, a function and a dword register. It then reads or writes a data window, and the block forwards those bytes to the selected function's configuration space. Both registers accept 1-, 2- and 4-byte accesses at a byte offset inside the register.

For each data access, the block forms an 8-bit key from the device and function fields. It looks that key up in a small table of attached targets, and each table entry has a valid bit and a programmable key. A hit is serialized toward the target one byte per cycle. A non-zero bus field, or a key with no matching target, is answered without touching any target: reads return all-ones, and writes are dropped or flagged as errors.

The host holds `req_valid` for one cycle while `busy` is low. One `rsp_done` pulse carries the response, and `rsp_err` and `rsp_rdata` are valid in that same cycle.

Top module: `cfg_port`

## Requirements
- R1: After reset the address register reads as zero, and `rsp_done`, `tgt_req` and `busy` are low.
- R2: An address-register access of n bytes at offset k covers register bytes k to k+n-1. Host lane i (bits 8i+7:8i of `req_wdata`/`rsp_rdata`) maps to register byte k+i. Bytes outside that range are left unchanged. A legal address-register access answers with `rsp_done` exactly one cycle after acceptance.
- R3: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 = reserved. A 4-byte access is legal only at offset 0, a 2-byte access only at offsets 0 to 2, and a 1-byte access at any offset. The reserved size is never legal. An illegal access to either register gives `rsp_err`=1 and `rsp_rdata`=0 one cycle after acceptance. It changes no state and makes no target cycle.
- R4: The address register holds the dword register number in bits 7:2, the function in bits 10:8, the device in bits 15:11 and the bus in bits 23:16. The target byte address is (register << 2) + offset.
- R5: While the bus field is non-zero, a data read returns 0xFF in every requested lane with no error. A data write is dropped without error. Neither makes a target cycle, and both answer one cycle after acceptance.
- R6: The lookup key is (device << 3) | function. An entry matches only while its valid bit is set. Table writes (`tab_we`) take effect from the next cycle.
- R7: On a lookup miss, a read returns 0xFF in every requested lane with no error, and a write reports `rsp_err`=1. Neither makes a target cycle.
- R8: On a hit, an n-byte access makes n consecutive `tgt_req` cycles in ascending byte-address order. Read lane i takes `tgt_rdata` from the i-th cycle, and write lane i is presented on `tgt_wdata` in the i-th cycle. `rsp_done` pulses for one cycle right after the last byte, n+1 cycles after acceptance.
- R9: Read lanes beyond the requested size return zero, and every write returns `rsp_rdata`=0.
- R10: `busy` is high from the cycle after acceptance through the `rsp_done` cycle. Requests presented while busy are ignored.
- R11: When several valid entries share a key, the lowest index is selected on `tgt_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe, taken while `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = address register, 1 = data window |
| req_off | input | 2 | Byte offset inside the register (low port bits) |
| req_size | input | 2 | Access size code (see R3) |
| req_wdata | input | 32 | Write lanes, lane 0 first |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error flag, valid with `rsp_done` |
| rsp_rdata | output | 32 | Read lanes, valid with `rsp_done` |
| tgt_req | output | 1 | Target byte cycle |
| tgt_write | output | 1 | Target cycle is a write |
| tgt_sel | output | IDXW | Index of the selected target |
| tgt_baddr | output | 8 | Configuration byte address |
| tgt_wdata | output | 8 | Write byte |
| tgt_rdata | input | 8 | Read byte, returned in the same cycle |
| tab_we | input | 1 | Table entry write |
| tab_idx | input | IDXW | Table entry index |
| tab_key | input | 8 | Key for the entry |
| tab_vld | input | 1 | Valid bit for the entry |

## Verification
The bench sweeps every size and offset pair on both registers. This catches a legality window that is off by one, such as a 2-byte access at offset 3 accepted or a 4-byte access at offset 1 let through. It also catches lanes that land on the wrong register byte. On the data window the bench counts the byte cycles and checks their order and the response latency, so a serializer that skips or repeats a byte, or pulses done early, shows up as a mismatch. The bench also covers the non-zero bus, an invalid entry, a duplicate key and a request arriving while busy. A design that confused those paths would reach a target it should not, fill the wrong lanes with 0xFF, or let the stray request overwrite the address register.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
   localparam int BYTES   = 4;
   localparam int DW      = 8 * BYTES;
   localparam int KEYW    = 8;
   localparam int BUS_LO  = 16;
   localparam int BUS_HI  = 23;
   localparam int DEV_LO  = 11;
   localparam int DEV_HI  = 15;
   localparam int FN_LO   = 8;
   localparam int FN_HI   = 10;
   localparam int REG_LO  = 2;
   localparam int REG_HI  = 7;

   typedef enum logic [1:0] {
      SZ_1B  = 2'd0,
      SZ_2B  = 2'd1,
      SZ_4B  = 2'd2,
      SZ_RSV = 2'd3
   } cfg_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_DONE = 2'd2
   } cfg_state_e;

   localparam logic SEL_ADDR = 1'b0;
   localparam logic SEL_DATA = 1'b1;
endpackage

// File: rtl/cfg_lane_check.sv
module cfg_lane_check
   import cfg_port_pkg::*;
(
   input  logic [1:0] size,
   input  logic [1:0] off,
   output logic       legal,
   output logic [2:0] nbytes
);
   always_comb begin
      case (cfg_size_e'(size))
         SZ_1B: begin
            nbytes = 3'd1;
            legal  = 1'b1;
         end
         SZ_2B: begin
            nbytes = 3'd2;
            legal  = (off != 2'd3);
         end
         SZ_4B: begin
            nbytes = 3'd4;
            legal  = (off == 2'd0);
         end
         default: begin
            nbytes = 3'd0;
            legal  = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg #(
   parameter int NBYTE = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [1:0]         off,
   input  logic [2:0]         nbytes,
   input  logic [8*NBYTE-1:0] wdata,
   output logic [8*NBYTE-1:0] q
);
   generate
      if (NBYTE != 4) begin : g_bad
         $error("cfg_addr_reg: NBYTE must be 4");
      end
      for (genvar j = 0; j < NBYTE; j++) begin : g_byte
         logic [2:0] rel;
         logic       hit;
         always_comb begin
            rel = 3'(j) - {1'b0, off};
            hit = (3'(j) >= {1'b0, off}) && (3'(j) < ({1'b0, off} + nbytes));
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[8*j +: 8] <= '0;
            else if (we && hit)
               q[8*j +: 8] <= wdata[8*rel[1:0] +: 8];
         end
      end
   endgenerate
endmodule

// File: rtl/cfg_tgt_table.sv
module cfg_tgt_table #(
   parameter int NTGT = 32,
   parameter int KEYW = 8,
   parameter int IDXW = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [IDXW-1:0] widx,
   input  logic [KEYW-1:0] wkey,
   input  logic            wvld,
   input  logic [KEYW-1:0] lkey,
   output logic            hit,
   output logic [IDXW-1:0] hidx
);
   logic [NTGT-1:0] match;

   generate
      if (NTGT < 1 || NTGT > (1 << IDXW)) begin : g_bad
         $error("cfg_tgt_table: NTGT does not fit IDXW");
      end
      for (genvar e = 0; e < NTGT; e++) begin : g_ent
         logic            vld;
         logic [KEYW-1:0] key;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld <= 1'b0;
               key <= '0;
            end else if (we && widx == IDXW'(e)) begin
               vld <= wvld;
               key <= wkey;
            end
         end
         assign match[e] = vld && (key == lkey);
      end
   endgenerate

   always_comb begin
      hit  = |match;
      hidx = '0;
      for (int e = NTGT - 1; e >= 0; e--)
         if (match[e]) hidx = IDXW'(e);
   end
endmodule

// File: rtl/cfg_port.sv
module cfg_port
   import cfg_port_pkg::*;
#(
   parameter int NTGT = 32,
   parameter int IDXW = (NTGT > 1) ? $clog2(NTGT) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            req_write,
   input  logic            req_sel,
   input  logic [1:0]      req_off,
   input  logic [1:0]      req_size,
   input  logic [31:0]     req_wdata,
   output logic            busy,
   output logic            rsp_done,
   output logic            rsp_err,
   output logic [31:0]     rsp_rdata,
   output logic            tgt_req,
   output logic            tgt_write,
   output logic [IDXW-1:0] tgt_sel,
   output logic [7:0]      tgt_baddr,
   output logic [7:0]      tgt_wdata,
   input  logic [7:0]      tgt_rdata,
   input  logic            tab_we,
   input  logic [IDXW-1:0] tab_idx,
   input  logic [7:0]      tab_key,
   input  logic            tab_vld
);
   generate
      if (NTGT < 1 || NTGT > 256) begin : g_bad
         $error("cfg_port: NTGT out of range");
      end
   endgenerate

   cfg_state_e      state;
   logic [1:0]      cnt;
   logic [2:0]      nb_q;
   logic [7:0]      base_q;
   logic [DW-1:0]   wbuf;
   logic [DW-1:0]   rbuf;
   logic            err_q;
   logic            wr_q;
   logic [IDXW-1:0] sel_q;

   logic            legal;
   logic [2:0]      nbytes;
   logic            accept;
   logic            aw_en;
   logic [DW-1:0]   addr_q;
   logic [KEYW-1:0] lkey;
   logic            hit;
   logic [IDXW-1:0] hidx;
   logic [DW-1:0]   addr_rd;
   logic [DW-1:0]   fill;
   logic            bus_nz;
   logic            last;

   assign accept = req_valid && (state == ST_IDLE);
   assign aw_en  = accept && legal && (req_sel == SEL_ADDR) && req_write;

   cfg_lane_check u_lane (
      .size   (req_size),
      .off    (req_off),
      .legal  (legal),
      .nbytes (nbytes)
   );

   cfg_addr_reg #(.NBYTE(BYTES)) u_areg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (aw_en),
      .off    (req_off),
      .nbytes (nbytes),
      .wdata  (req_wdata),
      .q      (addr_q)
   );

   assign lkey   = {addr_q[DEV_HI:DEV_LO], addr_q[FN_HI:FN_LO]};
   assign bus_nz = |addr_q[BUS_HI:BUS_LO];

   cfg_tgt_table #(.NTGT(NTGT), .KEYW(KEYW), .IDXW(IDXW)) u_tab (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tab_we),
      .widx  (tab_idx),
      .wkey  (tab_key),
      .wvld  (tab_vld),
      .lkey  (lkey),
      .hit   (hit),
      .hidx  (hidx)
   );

   always_comb begin
      for (int i = 0; i < BYTES; i++) begin
         logic [1:0] bi;
         bi = req_off + 2'(i);
         addr_rd[8*i +: 8] = (3'(i) < nbytes) ? addr_q[8*bi +: 8] : 8'h00;
         fill[8*i +: 8]    = (3'(i) < nbytes) ? 8'hFF : 8'h00;
      end
   end

   assign last = ({1'b0, cnt} == (nb_q - 3'd1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         nb_q   <= '0;
         base_q <= '0;
         wbuf   <= '0;
         rbuf   <= '0;
         err_q  <= 1'b0;
         wr_q   <= 1'b0;
         sel_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  err_q <= 1'b0;
                  rbuf  <= '0;
                  state <= ST_DONE;
                  if (!legal) begin
                     err_q <= 1'b1;
                  end else if (req_sel == SEL_ADDR) begin
                     if (!req_write) rbuf <= addr_rd;
                  end else if (bus_nz) begin
                     if (!req_write) rbuf <= fill;
                  end else if (!hit) begin
                     if (!req_write) rbuf <= fill;
                     err_q <= req_write;
                  end else begin
                     state  <= ST_XFER;
                     cnt    <= '0;
                     nb_q   <= nbytes;
                     base_q <= {addr_q[REG_HI:REG_LO], req_off};
                     wbuf   <= req_wdata;
                     wr_q   <= req_write;
                     sel_q  <= hidx;
                  end
               end
            end
            ST_XFER: begin
               if (!wr_q) rbuf[8*cnt +: 8] <= tgt_rdata;
               cnt <= cnt + 2'd1;
               if (last) state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign rsp_done  = (state == ST_DONE);
   assign rsp_err   = err_q;
   assign rsp_rdata = rbuf;
   assign tgt_req   = (state == ST_XFER);
   assign tgt_write = wr_q;
   assign tgt_sel   = sel_q;
   assign tgt_baddr = base_q + {6'd0, cnt};
   assign tgt_wdata = wbuf[8*cnt +: 8];
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        rsp_done,
   input logic        tgt_req,
   input logic [7:0]  tgt_baddr,
   input logic [31:0] addr_q
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!rsp_done && !tgt_req && !busy));

   assert_byte_ascend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_req && $past(tgt_req)) |-> (tgt_baddr == $past(tgt_baddr) + 8'd1));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   assert_no_tgt_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_req |-> (addr_q[23:16] == 8'd0));

   assert_tgt_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_req |-> (tgt_baddr[7:2] == addr_q[7:2]));

   assert_tgt_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_req || rsp_done) |-> busy);

   assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(addr_q));
endmodule

bind cfg_port cfg_port_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .rsp_done  (rsp_done),
   .tgt_req   (tgt_req),
   .tgt_baddr (tgt_baddr),
   .addr_q    (addr_q)
);

// File: tb/sim_cfg_port.sv
`timescale 1ns/1ps
module sim_cfg_port;
   localparam int NT = 4;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_sel = 1'b0;
   logic [1:0]    req_off = '0, req_size = '0;
   logic [31:0]   req_wdata = '0;
   logic          busy, rsp_done, rsp_err;
   logic [31:0]   rsp_rdata;
   logic          tgt_req, tgt_write;
   logic [IW-1:0] tgt_sel;
   logic [7:0]    tgt_baddr, tgt_wdata, tgt_rdata;
   logic          tab_we = 1'b0, tab_vld = 1'b0;
   logic [IW-1:0] tab_idx = '0;
   logic [7:0]    tab_key = '0;

   int errors = 0, checks = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   cfg_port #(.NTGT(NT)) u0 (.*);

   function automatic logic [7:0] rdm(input int s, input int a);
      return 8'((a * 3) + (s * 64) + 7);
   endfunction
   assign tgt_rdata = rdm(int'(tgt_sel), int'(tgt_baddr));

   logic [7:0] log_a [0:7];
   logic [7:0] log_d [0:7];
   logic [IW-1:0] log_s [0:7];
   logic log_w [0:7];
   int nlog = 0;
   always @(negedge clk) if (tgt_req) begin
      if (nlog < 8) begin
         log_a[nlog] = tgt_baddr; log_d[nlog] = tgt_wdata;
         log_s[nlog] = tgt_sel;   log_w[nlog] = tgt_write;
      end
      nlog++;
   end

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic int nbf(input int sz);
      return (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
   endfunction
   function automatic bit legalf(input int sz, input int off);
      return (sz == 0) || (sz == 1 && off < 3) || (sz == 2 && off == 0);
   endfunction

   task automatic acc(input logic sel, input logic wr, input int sz, input int off,
                      input logic [31:0] wd, output logic [31:0] rd, output logic er, output int lat);
      nlog = 0;
      @(negedge clk);
      req_valid = 1; req_sel = sel; req_write = wr;
      req_size = 2'(sz); req_off = 2'(off); req_wdata = wd;
      @(negedge clk);
      req_valid = 0;
      lat = 1;
      while (!rsp_done && lat < 20) begin @(negedge clk); lat++; end
      rd = rsp_rdata; er = rsp_err;
   endtask

   task automatic tab(input int idx, input logic [7:0] key, input logic vld);
      @(negedge clk);
      tab_we = 1; tab_idx = IW'(idx); tab_key = key; tab_vld = vld;
      @(negedge clk);
      tab_we = 0;
   endtask

   task automatic set_addr(input logic [31:0] a);
      logic [31:0] rd; logic er; int lat;
      acc(1'b0, 1'b1, 2, 0, a, rd, er, lat);
   endtask

   initial begin
      #(20 * 20000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd, am, exp; logic er; int lat;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!rsp_done && !tgt_req && !busy, "R1 idle", {rsp_done, tgt_req, busy}, 0);
      rst_n = 1;
      acc(1'b0, 1'b0, 2, 0, 0, rd, er, lat);
      chk(rd == 0 && !er, "R1 addr zero", rd, 0);

      // R2/R3 address register write sweep
      am = 0;
      for (int sz = 0; sz < 4; sz++) for (int off = 0; off < 4; off++) begin
         logic [31:0] pat;
         pat = 32'h11223344 + 32'((sz * 4 + off)) * 32'h01010101;
         acc(1'b0, 1'b1, sz, off, pat, rd, er, lat);
         chk(er == !legalf(sz, off) && lat == 1, "R3 addr write err", {er, 8'(lat)}, {!legalf(sz, off), 8'd1});
         if (legalf(sz, off))
            for (int i = 0; i < nbf(sz); i++) am[8*(off+i) +: 8] = pat[8*i +: 8];
         acc(1'b0, 1'b0, 2, 0, 0, rd, er, lat);
         chk(rd == am, "R2 addr byte write", rd, am);
      end
      // R2/R3/R9 address register read sweep
      for (int sz = 0; sz < 4; sz++) for (int off = 0; off < 4; off++) begin
         exp = 0;
         if (legalf(sz, off))
            for (int i = 0; i < nbf(sz); i++) exp[8*i +: 8] = am[8*(off+i) +: 8];
         acc(1'b0, 1'b0, sz, off, 0, rd, er, lat);
         chk(rd == exp && er == !legalf(sz, off), "R2 R3 R9 addr read", rd, exp);
      end

      // table: idx0 dev3/fn0, idx1 dev3/fn5, idx2 duplicate of idx0, idx3 invalid dev8/fn0
      tab(0, 8'h18, 1); tab(1, 8'h1D, 1); tab(2, 8'h18, 1); tab(3, 8'h40, 0);

      // R4/R8 data window reads and writes, dev3 fn0 reg5 (enable bit set)
      set_addr(32'h8000_1814);
      for (int sz = 0; sz < 4; sz++) for (int off = 0; off < 4; off++) begin
         int n; bit ok;
         n = legalf(sz, off) ? nbf(sz) : 0;
         exp = 0;
         for (int i = 0; i < n; i++) exp[8*i +: 8] = rdm(0, 8'h14 + off + i);
         acc(1'b1, 1'b0, sz, off, 0, rd, er, lat);
         if (n == 0) begin
            chk(er && rd == 0 && nlog == 0, "R3 data illegal", {er, 8'(nlog)}, {1'b1, 8'd0});
         end else begin
            chk(rd == exp && !er, "R8 R9 data read", rd, exp);
            chk(lat == n + 1 && nlog == n, "R8 read timing", {8'(lat), 8'(nlog)}, {8'(n + 1), 8'(n)});
            ok = 1;
            for (int i = 0; i < n; i++)
               ok &= (log_a[i] == 8'(8'h14 + off + i)) && !log_w[i] && (log_s[i] == 0);
            chk(ok, "R4 R11 read addr order", log_a[0], 8'(8'h14 + off));
         end
         acc(1'b1, 1'b1, sz, off, 32'hC3A5_5A3C, rd, er, lat);
         if (n > 0) begin
            ok = (nlog == n) && !er && rd == 0 && lat == n + 1;
            for (int i = 0; i < n; i++)
               ok &= (log_a[i] == 8'(8'h14 + off + i)) && log_w[i] && (log_d[i] == 8'(32'hC3A5_5A3C >> (8*i)));
            chk(ok, "R8 data write", {8'(nlog), 8'(lat)}, {8'(n), 8'(n + 1)});
         end
      end

      // R6 function field selects idx1
      set_addr(32'h0000_1D14);
      acc(1'b1, 1'b0, 0, 2, 0, rd, er, lat);
      chk(rd == {24'd0, rdm(1, 8'h16)} && log_s[0] == 1, "R6 key fn5", rd, {24'd0, rdm(1, 8'h16)});

      // R7 miss on invalid entry dev8 fn0
      set_addr(32'h0000_4008);
      acc(1'b1, 1'b0, 1, 1, 0, rd, er, lat);
      chk(rd == 32'h0000_FFFF && !er && nlog == 0 && lat == 1, "R7 miss read", rd, 32'h0000_FFFF);
      acc(1'b1, 1'b1, 1, 0, 32'h1234, rd, er, lat);
      chk(er && nlog == 0 && rd == 0, "R7 miss write", {er, 8'(nlog)}, {1'b1, 8'd0});
      // R6 entry becomes valid
      tab(3, 8'h40, 1);
      acc(1'b1, 1'b0, 0, 3, 0, rd, er, lat);
      chk(rd == {24'd0, rdm(3, 8'h0B)} && !er && log_s[0] == 3, "R6 valid entry", rd, {24'd0, rdm(3, 8'h0B)});

      // R5 non-zero bus
      set_addr(32'h0001_1814);
      acc(1'b1, 1'b0, 2, 0, 0, rd, er, lat);
      chk(rd == 32'hFFFF_FFFF && !er && nlog == 0 && lat == 1, "R5 bus read 4B", rd, 32'hFFFF_FFFF);
      acc(1'b1, 1'b0, 1, 1, 0, rd, er, lat);
      chk(rd == 32'h0000_FFFF && !er, "R5 bus read 2B", rd, 32'h0000_FFFF);
      acc(1'b1, 1'b1, 2, 0, 32'hFFFF_0000, rd, er, lat);
      chk(!er && nlog == 0 && rd == 0, "R5 bus write dropped", {er, 8'(nlog)}, 0);

      // R10 request while busy is ignored
      set_addr(32'h0000_1814);
      nlog = 0;
      @(negedge clk);
      req_valid = 1; req_sel = 1; req_write = 0; req_size = 2; req_off = 0;
      @(negedge clk);
      req_valid = 0;
      chk(busy, "R10 busy", busy, 1);
      @(negedge clk);
      req_valid = 1; req_sel = 0; req_write = 1; req_size = 2; req_off = 0; req_wdata = 32'hDEAD_BEEF;
      @(negedge clk);
      req_valid = 0;
      for (int k = 0; k < 10 && !rsp_done; k++) @(negedge clk);
      chk(nlog == 4, "R10 xfer count", nlog, 4);
      acc(1'b0, 1'b0, 2, 0, 0, rd, er, lat);
      chk(rd == 32'h0000_1814, "R10 addr kept", rd, 32'h0000_1814);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule